// File: doc/BRIEF.md
# CAN configuration guard and time-quantum clock front end

This block sits between a simple CPU register bus and the configuration storage of a CAN controller. Software can only reconfigure the controller while it is parked in initialization mode. It enters that mode by setting a request bit. The block confirms entry with an acknowledge bit that trails the request by two clock cycles. While that acknowledge is low, any write to a protected configuration register is thrown away, and a sticky violation flag records that it happened. The module enable bit takes only the first accepted write after reset. The two error counters are visible to software but cannot be changed from the bus.

The block also drives the controller's transmit pin. That pin is held recessive as soon as initialization or power-down is requested, and stays recessive until the initialization acknowledge has dropped again. Outside those modes the pin follows the bit engine's transmit bit.

A clock-source bit picks either the bus clock or an oscillator timing pulse as the CAN clock. A 6-bit prescaler divides that clock by 1 to 64 and produces the time-quantum pulse. The whole block runs on one clock. The oscillator side arrives as a one-cycle enable pulse. The bus has no data stream, so every pin is a plain control or status signal without back-pressure.

Top module: `canctl_guard`

## Requirements
- R1: Writes to the protected addresses take effect only while init_ack is 1. The protected addresses are control-1 (0x01), timing-0 (0x02), timing-1 (0x03), filter control (0x04), filter codes 0x08 to 0x0F and filter masks 0x10 to 0x17. Register 0x00 is always writable.
- R2: A protected write made while init_ack is 0 changes nothing and sets the violation flag, which is bit 7 of register 0x00 and also the viol_flag port. Writing 1 to bit 7 of register 0x00 clears the flag.
- R3: The acknowledge (port init_ack and bit 0 of register 0x01) copies the request (bit 0 of register 0x00) two cycles after the request register changes. This delay applies both when entering and when leaving initialization mode.
- R4: Register 0x05 reads rx_err_cnt and register 0x06 reads tx_err_cnt. Writes to either address have no effect.
- R5: The enable bit (bit 7 of register 0x01, port mod_en) takes its value from the first accepted write to 0x01 after reset. Every later write leaves it unchanged.
- R6: tx_out is 1 whenever the request bit, the acknowledge or the power-down bit (bit 1 of register 0x00) is set, starting from the cycle after the write. Otherwise tx_out equals tx_core.
- R7: Bit 6 of register 0x01 selects the CAN clock. A value of 1 counts every clk cycle. A value of 0 counts only the cycles in which osc_en is high.
- R8: tq_tick pulses once every (timing-0 bits 5:0 + 1) CAN clock counts. It stays low while init_ack is 1 or the enable bit is 0. Both 1:1 and 1:64 are supported.
- R9: After reset, all registers read 0, init_ack, mod_en, viol_flag and tq_tick are 0, and tx_out follows tx_core.
- R10: Bits 5:1 of register 0x01, timing-1, filter control and all filter codes and masks read back the last accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| osc_en | input | 1 | Oscillator clock pulse, one clk cycle wide |
| rx_err_cnt | input | 8 | Receive error count from the bit engine |
| tx_err_cnt | input | 8 | Transmit error count from the bit engine |
| tx_core | input | 1 | Transmit bit from the bit engine |
| tx_out | output | 1 | Transmit pin, 1 is recessive |
| tq_tick | output | 1 | Time-quantum pulse |
| init_ack | output | 1 | Initialization mode acknowledged |
| mod_en | output | 1 | Module enable |
| clk_sel | output | 1 | Selected clock source, 1 is the bus clock |
| viol_flag | output | 1 | Sticky protection violation flag |

## Verification
The bench goes after the two-cycle gap between request and acknowledge, in both directions. In that window a design that locked on the request rather than the acknowledge would accept writes too early or hold tx_out wrongly. It writes the enable bit a second and a third time: a design that treated enable as an ordinary bit would clear it, and one that counted dropped writes would lose the single allowed write. It also writes to the error counters and checks that the violation flag can be cleared. Finally it counts tq_tick at both ends of the 1 to 64 range, with the oscillator source, and while in initialization mode. An off-by-one prescaler, or one that keeps running during initialization, would show a tick count that differs from the expected value.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 8;
  localparam int FILT_N  = 8;
  localparam int DIV_W   = 6;

  localparam int A_CTRL0 = 0;
  localparam int A_CTRL1 = 1;
  localparam int A_BT0   = 2;
  localparam int A_BT1   = 3;
  localparam int A_IDAC  = 4;
  localparam int A_RXERR = 5;
  localparam int A_TXERR = 6;
  localparam int A_ACODE = 8;
  localparam int A_AMASK = 16;

  localparam int B_REQ    = 0;
  localparam int B_PD     = 1;
  localparam int B_VIOL   = 7;
  localparam int B_ACK    = 0;
  localparam int B_CLKSRC = 6;
  localparam int B_EN     = 7;

  function automatic logic is_prot(input int unsigned a, input int unsigned nfilt);
    return ((a >= A_CTRL1) && (a <= A_IDAC)) ||
           ((a >= A_ACODE) && (a < A_ACODE + nfilt)) ||
           ((a >= A_AMASK) && (a < A_AMASK + nfilt));
  endfunction
endpackage

// File: rtl/canctl_init_sync.sv
module canctl_init_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic ack_o
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= req_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], req_i};
    end
  endgenerate

  assign ack_o = chain[STAGES-1];
endmodule

// File: rtl/canctl_cfg_regs.sv
module canctl_cfg_regs
  import canctl_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int NFILT = FILT_N,
  parameter int DVW   = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          init_ack,
  input  logic [DW-1:0] rx_err,
  input  logic [DW-1:0] tx_err,
  output logic [DW-1:0] rdata,
  output logic          init_req,
  output logic          pd_req,
  output logic          viol,
  output logic          mod_en,
  output logic          clk_sel,
  output logic [DVW-1:0] div
);
  localparam int MISC_W = B_CLKSRC - 1;

  logic              wr_prot, wr_ok, wr_drop, wr_c0;
  logic              en_taken;
  logic [MISC_W-1:0] misc_q;
  logic [DW-1:0]     bt0_q, bt1_q, idac_q;
  logic [DW-1:0]     acode_q [NFILT];
  logic [DW-1:0]     amask_q [NFILT];

  assign wr_prot = we && is_prot(int'(addr), NFILT);
  assign wr_ok   = wr_prot && init_ack;
  assign wr_drop = wr_prot && !init_ack;
  assign wr_c0   = we && (addr == AW'(A_CTRL0));

  // control 0: request, power-down, sticky violation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req <= 1'b0;
      pd_req   <= 1'b0;
      viol     <= 1'b0;
    end else begin
      if (wr_c0) begin
        init_req <= wdata[B_REQ];
        pd_req   <= wdata[B_PD];
      end
      if (wr_drop)                  viol <= 1'b1;
      else if (wr_c0 && wdata[B_VIOL]) viol <= 1'b0;
    end
  end

  // control 1: write-once enable, clock source, misc
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_en   <= 1'b0;
      en_taken <= 1'b0;
      clk_sel  <= 1'b0;
      misc_q   <= '0;
    end else if (wr_ok && addr == AW'(A_CTRL1)) begin
      if (!en_taken) begin
        mod_en   <= wdata[B_EN];
        en_taken <= 1'b1;
      end
      clk_sel <= wdata[B_CLKSRC];
      misc_q  <= wdata[B_CLKSRC-1:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bt0_q  <= '0;
      bt1_q  <= '0;
      idac_q <= '0;
    end else if (wr_ok) begin
      if (addr == AW'(A_BT0))  bt0_q  <= wdata;
      if (addr == AW'(A_BT1))  bt1_q  <= wdata;
      if (addr == AW'(A_IDAC)) idac_q <= wdata;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NFILT; g++) begin : g_filt
      localparam logic [AW-1:0] CODE_A = AW'(A_ACODE + g);
      localparam logic [AW-1:0] MASK_A = AW'(A_AMASK + g);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acode_q[g] <= '0;
          amask_q[g] <= '0;
        end else if (wr_ok) begin
          if (addr == CODE_A) acode_q[g] <= wdata;
          if (addr == MASK_A) amask_q[g] <= wdata;
        end
      end
    end
  endgenerate

  assign div = bt0_q[DVW-1:0];

  always_comb begin
    rdata = '0;
    case (int'(addr))
      A_CTRL0: begin
        rdata[B_VIOL] = viol;
        rdata[B_PD]   = pd_req;
        rdata[B_REQ]  = init_req;
      end
      A_CTRL1: begin
        rdata[B_EN]           = mod_en;
        rdata[B_CLKSRC]       = clk_sel;
        rdata[B_CLKSRC-1:1]   = misc_q;
        rdata[B_ACK]          = init_ack;
      end
      A_BT0:   rdata = bt0_q;
      A_BT1:   rdata = bt1_q;
      A_IDAC:  rdata = idac_q;
      A_RXERR: rdata = rx_err;
      A_TXERR: rdata = tx_err;
      default: rdata = '0;
    endcase
    for (int i = 0; i < NFILT; i++) begin
      if (addr == AW'(A_ACODE + i)) rdata = acode_q[i];
      if (addr == AW'(A_AMASK + i)) rdata = amask_q[i];
    end
  end
endmodule

// File: rtl/canctl_tq_prescaler.sv
module canctl_tq_prescaler #(
  parameter int DVW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           src_bus,
  input  logic           osc_en,
  input  logic [DVW-1:0] div,
  output logic           tick
);
  logic           can_en;
  logic [DVW-1:0] cnt;

  assign can_en = src_bus | osc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (can_en) begin
      if (cnt == div) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/canctl_guard.sv
module canctl_guard
  import canctl_pkg::*;
#(
  parameter int AW        = ADDR_W,
  parameter int DW        = DATA_W,
  parameter int NFILT     = FILT_N,
  parameter int DVW       = DIV_W,
  parameter int ACK_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          osc_en,
  input  logic [DW-1:0] rx_err_cnt,
  input  logic [DW-1:0] tx_err_cnt,
  input  logic          tx_core,
  output logic          tx_out,
  output logic          tq_tick,
  output logic          init_ack,
  output logic          mod_en,
  output logic          clk_sel,
  output logic          viol_flag
);
  logic           init_req_w, pd_req_w;
  logic [DVW-1:0] div_w;

  canctl_init_sync #(.STAGES(ACK_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (init_req_w),
    .ack_o (init_ack)
  );

  canctl_cfg_regs #(.AW(AW), .DW(DW), .NFILT(NFILT), .DVW(DVW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .init_ack (init_ack),
    .rx_err   (rx_err_cnt),
    .tx_err   (tx_err_cnt),
    .rdata    (bus_rdata),
    .init_req (init_req_w),
    .pd_req   (pd_req_w),
    .viol     (viol_flag),
    .mod_en   (mod_en),
    .clk_sel  (clk_sel),
    .div      (div_w)
  );

  canctl_tq_prescaler #(.DVW(DVW)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mod_en && !init_ack),
    .src_bus (clk_sel),
    .osc_en  (osc_en),
    .div     (div_w),
    .tick    (tq_tick)
  );

  // recessive while any quiet mode is requested or still acknowledged
  assign tx_out = (init_req_w || init_ack || pd_req_w) ? 1'b1 : tx_core;
endmodule

// File: rtl/canctl_guard_chk.sv
module canctl_guard_chk
  import canctl_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int NFILT = FILT_N
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          init_req,
  input logic          init_ack,
  input logic          tx_out,
  input logic          mod_en,
  input logic          tq_tick,
  input logic          viol_flag
);
  AST_ACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ack) |-> $past(init_req, 2)); // R3
  AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_ack) |-> !$past(init_req, 2)); // R3
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_prot(int'(bus_addr), NFILT) && !init_ack) |=> viol_flag); // R2
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_flag) |-> $past(bus_we && is_prot(int'(bus_addr), NFILT) && !init_ack)); // R1
  AST_PD_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(A_CTRL0) && bus_wdata[B_PD]) |=> tx_out); // R6
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mod_en |=> mod_en); // R5
  AST_TICK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |-> $past(mod_en && !init_ack)); // R8
endmodule

bind canctl_guard canctl_guard_chk #(.AW(AW), .DW(DW), .NFILT(NFILT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .init_req  (init_req_w),
  .init_ack  (init_ack),
  .tx_out    (tx_out),
  .mod_en    (mod_en),
  .tq_tick   (tq_tick),
  .viol_flag (viol_flag)
);

// File: tb/canctl_guard_bench.sv
module canctl_guard_bench;
  localparam int CLK_P = 10;
  localparam int NV    = 17;

  typedef struct packed {
    logic       we;
    logic [4:0] waddr;
    logic [7:0] wdata;
    logic [4:0] raddr;
    logic [7:0] expv;
    logic [3:0] rq;
  } vec_t;

  // write (optional), then read raddr three cycles later and compare
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'h00, 8'h00, 5'h00, 8'h00, 4'd9},  // R9 control 0 after reset
    '{1'b1, 5'h03, 8'h5A, 5'h03, 8'h00, 4'd1},  // R1 locked write dropped
    '{1'b0, 5'h00, 8'h00, 5'h00, 8'h80, 4'd2},  // R2 flag set
    '{1'b1, 5'h00, 8'h80, 5'h00, 8'h00, 4'd2},  // R2 write-1 clear
    '{1'b1, 5'h00, 8'h01, 5'h01, 8'h01, 4'd3},  // R3 ack after request
    '{1'b1, 5'h03, 8'h5A, 5'h03, 8'h5A, 4'd1},  // R1 accepted in init
    '{1'b1, 5'h0B, 8'h33, 5'h0B, 8'h33, 4'd10}, // R10 filter code 3
    '{1'b1, 5'h17, 8'hC4, 5'h17, 8'hC4, 4'd10}, // R10 filter mask 7
    '{1'b1, 5'h04, 8'h12, 5'h04, 8'h12, 4'd10}, // R10 filter control
    '{1'b1, 5'h05, 8'hFF, 5'h05, 8'h21, 4'd4},  // R4 rx counter
    '{1'b1, 5'h06, 8'h00, 5'h06, 8'h37, 4'd4},  // R4 tx counter
    '{1'b1, 5'h01, 8'hC0, 5'h01, 8'hC1, 4'd5},  // R5 first enable write
    '{1'b1, 5'h01, 8'h40, 5'h01, 8'hC1, 4'd5},  // R5 second write ignored
    '{1'b1, 5'h01, 8'h06, 5'h01, 8'h87, 4'd10}, // R10 misc bits, clksrc off
    '{1'b1, 5'h00, 8'h00, 5'h01, 8'h86, 4'd3},  // R3 ack drops
    '{1'b1, 5'h03, 8'h11, 5'h03, 8'h5A, 4'd1},  // R1 locked again
    '{1'b1, 5'h02, 8'h07, 5'h02, 8'h00, 4'd1}   // R1 timing-0 locked
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       osc_en = 1'b0;
  logic       osc_run = 1'b0;
  logic [7:0] rx_err_cnt = 8'h21;
  logic [7:0] tx_err_cnt = 8'h37;
  logic       tx_core = 1'b0;
  logic       tx_out, tq_tick, init_ack, mod_en, clk_sel, viol_flag;

  int n_chk = 0;
  int n_bad = 0;

  canctl_guard u_canctl_guard (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_en(osc_en),
    .rx_err_cnt(rx_err_cnt), .tx_err_cnt(tx_err_cnt), .tx_core(tx_core),
    .tx_out(tx_out), .tq_tick(tq_tick), .init_ack(init_ack),
    .mod_en(mod_en), .clk_sel(clk_sel), .viol_flag(viol_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (osc_run) osc_en = ~osc_en; else osc_en = 1'b0;

  task automatic check(input string what, input int rq, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL R%0d %s: got %0h expected %0h", rq, what, act, expv);
    end
  endtask

  task automatic write_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic set_mode(input logic [7:0] c0);
    write_reg(5'h00, c0);
    repeat (2) @(negedge clk);
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (tq_tick) c++;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired, run hung");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("reset init_ack", 9, init_ack, 0);
    check("reset mod_en", 9, mod_en, 0);
    check("reset viol_flag", 9, viol_flag, 0);
    check("reset tq_tick", 9, tq_tick, 0);
    check("reset tx_out follows tx_core", 9, tx_out, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_we = VECS[i].we; bus_addr = VECS[i].waddr; bus_wdata = VECS[i].wdata;
      @(negedge clk);
      bus_we = 1'b0; bus_addr = VECS[i].raddr;
      repeat (2) @(negedge clk);
      check($sformatf("vector %0d", i), int'(VECS[i].rq), bus_rdata, VECS[i].expv);
    end

    // R2 flag from the last locked writes, then clear
    bus_addr = 5'h00;
    #1 check("flag after locked write", 2, viol_flag, 1);
    write_reg(5'h00, 8'h80);
    check("flag cleared", 2, viol_flag, 0);

    // R6 transmit forcing
    check("tx follows core in normal", 6, tx_out, 0);
    write_reg(5'h00, 8'h02);
    check("tx recessive on power-down", 6, tx_out, 1);
    write_reg(5'h00, 8'h00);
    check("tx back to core", 6, tx_out, 0);
    write_reg(5'h00, 8'h01);
    check("tx recessive on init request", 6, tx_out, 1);
    check("ack still low one cycle after request", 3, init_ack, 0);
    @(negedge clk);
    check("ack still low two cycles after request", 3, init_ack, 0);
    @(negedge clk);
    check("ack high three cycles after request", 3, init_ack, 1);

    // R8 divide by 4 on bus clock, held while in init
    write_reg(5'h02, 8'h03);
    write_reg(5'h01, 8'h40);
    check("clock select bus", 7, clk_sel, 1);
    count_ticks(20, c);
    check("no ticks in init", 8, c, 0);
    write_reg(5'h00, 8'h00);
    check("ack held one cycle after exit", 3, init_ack, 1);
    check("tx recessive until ack drops", 6, tx_out, 1);
    @(negedge clk);
    check("ack held two cycles after exit", 3, init_ack, 1);
    @(negedge clk);
    check("ack low after exit", 3, init_ack, 0);
    check("tx follows core after exit", 6, tx_out, 0);
    repeat (8) @(negedge clk);
    count_ticks(40, c);
    check("ticks at ratio 4, bus clock", 8, c, 10);

    // R7 oscillator source, pulses every other cycle
    set_mode(8'h01);
    write_reg(5'h01, 8'h00);
    check("clock select oscillator", 7, clk_sel, 0);
    check("enable kept after third write", 5, mod_en, 1);
    osc_run = 1'b1;
    set_mode(8'h00);
    repeat (16) @(negedge clk);
    count_ticks(40, c);
    check("ticks at ratio 4, oscillator", 7, c, 5);
    osc_run = 1'b0;

    // R8 extremes of the ratio
    set_mode(8'h01);
    write_reg(5'h02, 8'h3F);
    write_reg(5'h01, 8'h40);
    set_mode(8'h00);
    repeat (4) @(negedge clk);
    count_ticks(128, c);
    check("ticks at ratio 64", 8, c, 2);
    set_mode(8'h01);
    write_reg(5'h02, 8'h00);
    set_mode(8'h00);
    repeat (2) @(negedge clk);
    count_ticks(20, c);
    check("ticks at ratio 1", 8, c, 20);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule